// File: doc/BRIEF.md
# PHY link state monitor

This block watches an Ethernet PHY and keeps the MAC side informed of the link. When the PHY raises its interrupt line, the block reads the PHY's link/negotiation status register. It does this through a plain management-register request port: address, write flag, write data, read data and a done strobe. The serial management framing sits behind that port and is outside this block. From the status word it takes link-good and the line speed. While the link is good it also reads the local and partner advertisement registers and resolves pause flow control through a 16-entry table. At the end of each check it clears every pending PHY interrupt.

The block keeps the last known link state and speed. It reports changes as one-cycle events that carry the new speed. A speed change on a link that stays up is reported as a down event and then an up event. A one-cycle start pulse runs an initialisation sequence. That sequence clears pending interrupts, programs the interrupt mask, rewrites the advertisement register to request asymmetric pause with gigabit only, and restarts auto-negotiation.

Top module: `phy_link_monitor`

## Requirements
- R1: After reset the link state and the speed are both unknown: link_up=0, link_speed=0, flow_ctrl=0, no events, no request, busy=0. The first check that reads a good link therefore always produces an up event.
- R2: Link status is read from register address 0x11. Bit 2 set means the link is good. Bits [4:3] encode the speed as 00=10 Mb/s, 01=100 Mb/s and 10=1000 Mb/s, and 11 means unknown. On the speed outputs the codes are 0=unknown, 1=10 Mb/s, 2=100 Mb/s and 3=1000 Mb/s.
- R3: A change of link state produces exactly one event. Going to up gives evt_up with the decoded speed. Going from up or unknown to down gives evt_down with speed code 0. A check with unchanged state and speed gives no event. While the link is not up, link_speed is 0.
- R4: If the link stays up and the decoded speed differs from the stored one, evt_down (speed 0) is pulsed. It is followed in the very next cycle by evt_up with the new speed.
- R5: An interrupt-driven check performs these transfers in order: read 0x11; only if the link is good, read 0x04 and then read 0x05; finally write 0xFFFF to 0x17.
- R6: flow_ctrl is recomputed only on a check that finds the link good, and is held otherwise. The table index is {local reg 0x04 bits [11:10], partner reg 0x05 bits [11:10]}, where bit 11 is asymmetric direction and bit 10 is pause. Indices 5, 7, 13 and 15 give symmetric (3). Index 11 gives we-transmit (1). Index 14 gives we-receive (2). All other indices give none (0).
- R7: A pulse on init_start performs these transfers in order: write 0xFFFF to 0x17; write 0xC790 to 0x15; read 0x04; write back the value read with bit 10 and bits [8:5] cleared and bit 11 set; read 0x00; write back the value read with bit 9 set.
- R8: Interrupt rising edges that arrive while a sequence runs are latched, and any number of them collapse into one further check run after the current sequence. When an init request and a check are both pending, the init runs first.
- R9: Once mgmt_req is raised, the address, write flag and write data stay stable until the cycle in which mgmt_done is sampled high. Each cycle with mgmt_req and mgmt_done both high completes one transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| phy_irq | input | 1 | PHY interrupt; a rising edge requests a status check |
| init_start | input | 1 | One-cycle pulse requesting the init sequence |
| mgmt_req | output | 1 | Management transfer request |
| mgmt_we | output | 1 | 1 = write, 0 = read |
| mgmt_addr | output | 5 | PHY register address |
| mgmt_wdata | output | 16 | Write data |
| mgmt_rdata | input | 16 | Read data, valid with mgmt_done |
| mgmt_done | input | 1 | Transfer complete strobe |
| link_up | output | 1 | Stored link state is up |
| link_speed | output | 2 | Stored speed code |
| flow_ctrl | output | 2 | Resolved pause mode |
| evt_up | output | 1 | One-cycle link-up event |
| evt_down | output | 1 | One-cycle link-down event |
| evt_speed | output | 2 | Speed code carried with the event |
| busy | output | 1 | A sequence is running or pending |

## Verification
On every cycle, the embedded assertions check several rules. The request fields hold steady until done. The interrupt-clear and mask writes carry their fixed values. Up and down events never coincide. A down event raised on a still-up link is followed by an up event. The speed stays unknown while the link is not up, and flow control moves only on a check that finds the link good. The correct order of transfers, the decoding of each speed code, the pause-table results for each index, and the collapsing of interrupts that arrive during a busy sequence are shown only by the bench's scenarios. The bench's behavioural PHY and event model compares every completed transfer and every event against its predictions.

// File: rtl/phy_mon_pkg.sv
`timescale 1ns/1ps
package phy_mon_pkg;
  localparam int RA_W = 5;
  localparam int RD_W = 16;
  localparam int PB_W = 2;

  localparam logic [RA_W-1:0] A_CTRL  = 5'h00;
  localparam logic [RA_W-1:0] A_ADV   = 5'h04;
  localparam logic [RA_W-1:0] A_PART  = 5'h05;
  localparam logic [RA_W-1:0] A_LSTAT = 5'h11;
  localparam logic [RA_W-1:0] A_IMASK = 5'h15;
  localparam logic [RA_W-1:0] A_ICLR  = 5'h17;

  localparam logic [RD_W-1:0] ALL_ONES = 16'hFFFF;
  localparam logic [RD_W-1:0] ADV_CLR  = 16'h05E0;
  localparam logic [RD_W-1:0] ADV_SET  = 16'h0800;
  localparam logic [RD_W-1:0] CTL_RSTAN = 16'h0200;

  typedef enum logic [1:0] {SPD_UNK = 2'd0, SPD_10 = 2'd1, SPD_100 = 2'd2, SPD_1G = 2'd3} speed_t;
  typedef enum logic [1:0] {FC_NONE = 2'd0, FC_WE_TX = 2'd1, FC_WE_RX = 2'd2, FC_SYMM = 2'd3} fc_t;
  typedef enum logic [1:0] {LNK_UNK = 2'd0, LNK_DOWN = 2'd1, LNK_UP = 2'd2} link_t;

  typedef enum logic [3:0] {
    S_IDLE, S_I_CLR, S_I_MASK, S_I_ADV_RD, S_I_ADV_WR, S_I_CTL_RD, S_I_CTL_WR,
    S_C_STAT, S_C_LOC, S_C_PART, S_C_UPD, S_C_CLR
  } seq_t;

  function automatic fc_t fc_rule(input logic [3:0] idx);
    case (idx)
      4'd5, 4'd7, 4'd13, 4'd15: fc_rule = FC_SYMM;
      4'd11:                    fc_rule = FC_WE_TX;
      4'd14:                    fc_rule = FC_WE_RX;
      default:                  fc_rule = FC_NONE;
    endcase
  endfunction
endpackage

// File: rtl/plm_status_decode.sv
`timescale 1ns/1ps
module plm_status_decode import phy_mon_pkg::*; #(
  parameter int LINK_BIT = 2,
  parameter int SPD_LSB  = 3
) (
  input  logic [RD_W-1:0] stat,
  output logic            good,
  output speed_t          spd
);
  assign good = stat[LINK_BIT];

  always_comb begin
    case (stat[SPD_LSB +: 2])
      2'b00:   spd = SPD_10;
      2'b01:   spd = SPD_100;
      2'b10:   spd = SPD_1G;
      default: spd = SPD_UNK;
    endcase
  end
endmodule

// File: rtl/plm_pause_resolve.sv
`timescale 1ns/1ps
module plm_pause_resolve import phy_mon_pkg::*; (
  input  logic [PB_W-1:0] loc,
  input  logic [PB_W-1:0] part,
  output fc_t             fc
);
  localparam int IDX_W = 2 * PB_W;
  localparam int LUT_N = 1 << IDX_W;

  logic [1:0] lut [LUT_N];

  for (genvar i = 0; i < LUT_N; i++) begin : g_lut
    assign lut[i] = fc_rule(4'(i));
  end

  assign fc = fc_t'(lut[{loc, part}]);
endmodule

// File: rtl/plm_seq.sv
`timescale 1ns/1ps
module plm_seq import phy_mon_pkg::*; #(
  parameter logic [RD_W-1:0] INT_MASK = 16'hC790
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            phy_irq,
  input  logic            init_start,
  output logic            mgmt_req,
  output logic            mgmt_we,
  output logic [RA_W-1:0] mgmt_addr,
  output logic [RD_W-1:0] mgmt_wdata,
  input  logic [RD_W-1:0] mgmt_rdata,
  input  logic            mgmt_done,
  output logic            upd,
  output logic            good,
  output speed_t          spd,
  output logic [PB_W-1:0] loc_bits,
  output logic [PB_W-1:0] part_bits,
  output logic            busy
);
  seq_t            state_q, state_n;
  logic            irq_q, irq_pend_q, init_pend_q;
  logic            irq_pend_n, init_pend_n;
  logic [RD_W-1:0] hold_q;
  logic            hold_en;
  logic            good_q, stat_en;
  speed_t          spd_q;
  logic [PB_W-1:0] loc_q, part_q;
  logic            loc_en, part_en;
  logic            rd_good;
  speed_t          rd_spd;
  logic            take_init, take_irq, xfer;

  plm_status_decode #(.LINK_BIT(2), .SPD_LSB(3)) u_dec (
    .stat(mgmt_rdata), .good(rd_good), .spd(rd_spd)
  );

  assign xfer      = mgmt_req && mgmt_done;
  assign take_init = (state_q == S_IDLE) && init_pend_q;
  assign take_irq  = (state_q == S_IDLE) && !init_pend_q && irq_pend_q;

  assign init_pend_n = init_start || (init_pend_q && !take_init);
  assign irq_pend_n  = (phy_irq && !irq_q) || (irq_pend_q && !take_irq);

  always_comb begin
    mgmt_req   = 1'b1;
    mgmt_we    = 1'b0;
    mgmt_addr  = A_LSTAT;
    mgmt_wdata = '0;
    case (state_q)
      S_I_CLR:    begin mgmt_we = 1'b1; mgmt_addr = A_ICLR;  mgmt_wdata = ALL_ONES; end
      S_I_MASK:   begin mgmt_we = 1'b1; mgmt_addr = A_IMASK; mgmt_wdata = INT_MASK; end
      S_I_ADV_RD: mgmt_addr = A_ADV;
      S_I_ADV_WR: begin mgmt_we = 1'b1; mgmt_addr = A_ADV;   mgmt_wdata = (hold_q & ~ADV_CLR) | ADV_SET; end
      S_I_CTL_RD: mgmt_addr = A_CTRL;
      S_I_CTL_WR: begin mgmt_we = 1'b1; mgmt_addr = A_CTRL;  mgmt_wdata = hold_q | CTL_RSTAN; end
      S_C_STAT:   mgmt_addr = A_LSTAT;
      S_C_LOC:    mgmt_addr = A_ADV;
      S_C_PART:   mgmt_addr = A_PART;
      S_C_CLR:    begin mgmt_we = 1'b1; mgmt_addr = A_ICLR;  mgmt_wdata = ALL_ONES; end
      default:    mgmt_req = 1'b0;
    endcase
  end

  always_comb begin
    state_n = state_q;
    case (state_q)
      S_IDLE:     if (take_init) state_n = S_I_CLR;
                  else if (take_irq) state_n = S_C_STAT;
      S_I_CLR:    if (xfer) state_n = S_I_MASK;
      S_I_MASK:   if (xfer) state_n = S_I_ADV_RD;
      S_I_ADV_RD: if (xfer) state_n = S_I_ADV_WR;
      S_I_ADV_WR: if (xfer) state_n = S_I_CTL_RD;
      S_I_CTL_RD: if (xfer) state_n = S_I_CTL_WR;
      S_I_CTL_WR: if (xfer) state_n = S_IDLE;
      S_C_STAT:   if (xfer) state_n = rd_good ? S_C_LOC : S_C_UPD;
      S_C_LOC:    if (xfer) state_n = S_C_PART;
      S_C_PART:   if (xfer) state_n = S_C_UPD;
      S_C_UPD:    state_n = S_C_CLR;
      S_C_CLR:    if (xfer) state_n = S_IDLE;
      default:    state_n = S_IDLE;
    endcase
  end

  assign hold_en = xfer && ((state_q == S_I_ADV_RD) || (state_q == S_I_CTL_RD));
  assign stat_en = xfer && (state_q == S_C_STAT);
  assign loc_en  = xfer && (state_q == S_C_LOC);
  assign part_en = xfer && (state_q == S_C_PART);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      irq_q       <= 1'b0;
      irq_pend_q  <= 1'b0;
      init_pend_q <= 1'b0;
      hold_q      <= '0;
      good_q      <= 1'b0;
      spd_q       <= SPD_UNK;
      loc_q       <= '0;
      part_q      <= '0;
    end else begin
      state_q     <= state_n;
      irq_q       <= phy_irq;
      irq_pend_q  <= irq_pend_n;
      init_pend_q <= init_pend_n;
      if (hold_en) hold_q <= mgmt_rdata;
      if (stat_en) begin
        good_q <= rd_good;
        spd_q  <= rd_spd;
      end
      if (loc_en)  loc_q  <= mgmt_rdata[11:10];
      if (part_en) part_q <= mgmt_rdata[11:10];
    end
  end

  assign upd       = (state_q == S_C_UPD);
  assign good      = good_q;
  assign spd       = spd_q;
  assign loc_bits  = loc_q;
  assign part_bits = part_q;
  assign busy      = (state_q != S_IDLE) || irq_pend_q || init_pend_q;

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mgmt_req && !mgmt_done) |=> (mgmt_req && $stable(mgmt_addr) && $stable(mgmt_we) && $stable(mgmt_wdata)));

  assert_clr_ones_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mgmt_req && mgmt_we && mgmt_addr == A_ICLR) |-> (mgmt_wdata == ALL_ONES));

  assert_mask_val_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mgmt_req && mgmt_we && mgmt_addr == A_IMASK) |-> (mgmt_wdata == INT_MASK));
endmodule

// File: rtl/plm_link_track.sv
`timescale 1ns/1ps
module plm_link_track import phy_mon_pkg::*; (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   upd,
  input  logic   good,
  input  speed_t spd,
  input  fc_t    fc_in,
  output logic   link_up,
  output speed_t link_speed,
  output fc_t    flow_ctrl,
  output logic   evt_up,
  output logic   evt_down,
  output speed_t evt_speed
);
  link_t  lst_q, lst_n;
  speed_t spd_q, spd_n, es_q, es_n;
  fc_t    fc_q, fc_n;
  logic   eu_q, eu_n, ed_q, ed_n, upp_q, upp_n;

  always_comb begin
    lst_n = lst_q;
    spd_n = spd_q;
    fc_n  = fc_q;
    eu_n  = 1'b0;
    ed_n  = 1'b0;
    es_n  = SPD_UNK;
    upp_n = 1'b0;
    if (upp_q) begin
      eu_n = 1'b1;
      es_n = spd_q;
    end
    if (upd) begin
      if (good) begin
        fc_n = fc_in;
        if (lst_q != LNK_UP) begin
          eu_n  = 1'b1;
          es_n  = spd;
          lst_n = LNK_UP;
          spd_n = spd;
        end else if (spd != spd_q) begin
          ed_n  = 1'b1;
          upp_n = 1'b1;
          spd_n = spd;
        end
      end else if (lst_q != LNK_DOWN) begin
        ed_n  = 1'b1;
        lst_n = LNK_DOWN;
        spd_n = SPD_UNK;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lst_q <= LNK_UNK;
      spd_q <= SPD_UNK;
      fc_q  <= FC_NONE;
      eu_q  <= 1'b0;
      ed_q  <= 1'b0;
      es_q  <= SPD_UNK;
      upp_q <= 1'b0;
    end else begin
      lst_q <= lst_n;
      spd_q <= spd_n;
      fc_q  <= fc_n;
      eu_q  <= eu_n;
      ed_q  <= ed_n;
      es_q  <= es_n;
      upp_q <= upp_n;
    end
  end

  assign link_up    = (lst_q == LNK_UP);
  assign link_speed = spd_q;
  assign flow_ctrl  = fc_q;
  assign evt_up     = eu_q;
  assign evt_down   = ed_q;
  assign evt_speed  = es_q;

  assert_one_event_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(evt_up && evt_down));

  assert_down_unk_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !link_up |-> (link_speed == SPD_UNK));

  assert_split_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_down && link_up) |=> evt_up);

  assert_fc_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(upd && good) |=> $stable(flow_ctrl));
endmodule

// File: rtl/phy_link_monitor.sv
`timescale 1ns/1ps
module phy_link_monitor import phy_mon_pkg::*; #(
  parameter logic [15:0] INT_MASK = 16'hC790
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        phy_irq,
  input  logic        init_start,
  output logic        mgmt_req,
  output logic        mgmt_we,
  output logic [4:0]  mgmt_addr,
  output logic [15:0] mgmt_wdata,
  input  logic [15:0] mgmt_rdata,
  input  logic        mgmt_done,
  output logic        link_up,
  output logic [1:0]  link_speed,
  output logic [1:0]  flow_ctrl,
  output logic        evt_up,
  output logic        evt_down,
  output logic [1:0]  evt_speed,
  output logic        busy
);
  logic [1:0]      rst_sync_q;
  logic            rst_s;
  logic            upd, good;
  speed_t          spd, trk_spd, trk_es;
  fc_t             fc_res, trk_fc;
  logic [PB_W-1:0] loc_bits, part_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  plm_seq #(.INT_MASK(INT_MASK)) u_seq (
    .clk(clk), .rst_n(rst_s), .phy_irq(phy_irq), .init_start(init_start),
    .mgmt_req(mgmt_req), .mgmt_we(mgmt_we), .mgmt_addr(mgmt_addr),
    .mgmt_wdata(mgmt_wdata), .mgmt_rdata(mgmt_rdata), .mgmt_done(mgmt_done),
    .upd(upd), .good(good), .spd(spd), .loc_bits(loc_bits),
    .part_bits(part_bits), .busy(busy)
  );

  plm_pause_resolve u_pause (
    .loc(loc_bits), .part(part_bits), .fc(fc_res)
  );

  plm_link_track u_track (
    .clk(clk), .rst_n(rst_s), .upd(upd), .good(good), .spd(spd),
    .fc_in(fc_res), .link_up(link_up), .link_speed(trk_spd),
    .flow_ctrl(trk_fc), .evt_up(evt_up), .evt_down(evt_down),
    .evt_speed(trk_es)
  );

  assign link_speed = trk_spd;
  assign flow_ctrl  = trk_fc;
  assign evt_speed  = trk_es;
endmodule

// File: tb/test_phy_link_monitor.sv
`timescale 1ns/1ps
module test_phy_link_monitor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        phy_irq = 1'b0;
  logic        init_start = 1'b0;
  logic        mgmt_req, mgmt_we;
  logic [4:0]  mgmt_addr;
  logic [15:0] mgmt_wdata;
  logic [15:0] mgmt_rdata = '0;
  logic        mgmt_done = 1'b0;
  logic        link_up, evt_up, evt_down, busy;
  logic [1:0]  link_speed, flow_ctrl, evt_speed;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit live = 0;

  logic [15:0] regs [32];
  int          ex_addr [$];
  bit          ex_we   [$];
  logic [15:0] ex_data [$];
  string       ex_tag  [$];
  int          ev_kind [$];
  int          ev_spd  [$];
  string       ev_tag  [$];
  int m_link = 0;
  int m_spd  = 0;
  int m_fc   = 0;

  always #2.5 clk = ~clk;

  phy_link_monitor i_phy_link_monitor (
    .clk(clk), .rst_n(rst_n), .phy_irq(phy_irq), .init_start(init_start),
    .mgmt_req(mgmt_req), .mgmt_we(mgmt_we), .mgmt_addr(mgmt_addr),
    .mgmt_wdata(mgmt_wdata), .mgmt_rdata(mgmt_rdata), .mgmt_done(mgmt_done),
    .link_up(link_up), .link_speed(link_speed), .flow_ctrl(flow_ctrl),
    .evt_up(evt_up), .evt_down(evt_down), .evt_speed(evt_speed), .busy(busy)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic int dec_spd(input logic [1:0] b);
    case (b)
      2'b00: return 1;
      2'b01: return 2;
      2'b10: return 3;
      default: return 0;
    endcase
  endfunction

  function automatic int pause_of(input logic [3:0] idx);
    if (idx == 5 || idx == 7 || idx == 13 || idx == 15) return 3;
    if (idx == 11) return 1;
    if (idx == 14) return 2;
    return 0;
  endfunction

  task automatic push_tr(input int a, input bit w, input logic [15:0] d, input string t);
    ex_addr.push_back(a); ex_we.push_back(w); ex_data.push_back(d); ex_tag.push_back(t);
  endtask

  task automatic push_ev(input int k, input int s, input string t);
    ev_kind.push_back(k); ev_spd.push_back(s); ev_tag.push_back(t);
  endtask

  // behavioural prediction of one status check
  task automatic expect_check();
    logic [15:0] st;
    int sp;
    st = regs[5'h11];
    sp = dec_spd(st[4:3]);
    push_tr(5'h11, 0, '0, "R5");
    if (st[2]) begin
      push_tr(5'h04, 0, '0, "R5");
      push_tr(5'h05, 0, '0, "R5");
      m_fc = pause_of({regs[5'h04][11:10], regs[5'h05][11:10]});
      if (m_link != 2) begin
        push_ev(1, sp, "R3");
        m_link = 2; m_spd = sp;
      end else if (sp != m_spd) begin
        push_ev(0, 0, "R4");
        push_ev(1, sp, "R4");
        m_spd = sp;
      end
    end else if (m_link != 1) begin
      push_ev(0, 0, "R3");
      m_link = 1; m_spd = 0;
    end
    push_tr(5'h17, 1, 16'hFFFF, "R5");
  endtask

  task automatic expect_init();
    push_tr(5'h17, 1, 16'hFFFF, "R7");
    push_tr(5'h15, 1, 16'hC790, "R7");
    push_tr(5'h04, 0, '0, "R7");
    push_tr(5'h04, 1, (regs[5'h04] & ~16'h05E0) | 16'h0800, "R7");
    push_tr(5'h00, 0, '0, "R7");
    push_tr(5'h00, 1, regs[5'h00] | 16'h0200, "R7");
  endtask

  // PHY register model answering the management port
  initial begin
    int wcnt = 0;
    int lat = 0;
    int first_addr = 0;
    forever begin
      @(negedge clk);
      if (mgmt_done) begin
        mgmt_done = 1'b0;
        wcnt = 0;
      end else if (live && mgmt_req) begin
        wcnt++;
        if (wcnt == 1) first_addr = mgmt_addr;
        else chk(mgmt_addr == first_addr, "R9 addr held", mgmt_addr, first_addr);
        if (wcnt >= 1 + (lat % 3)) begin
          lat++;
          if (ex_addr.size() == 0) begin
            chk(0, "R5 unexpected transfer", mgmt_addr, 0);
          end else begin
            int a; bit w; logic [15:0] d; string t;
            a = ex_addr.pop_front(); w = ex_we.pop_front();
            d = ex_data.pop_front(); t = ex_tag.pop_front();
            chk(mgmt_addr == a, {t, " addr"}, mgmt_addr, a);
            chk(mgmt_we == w, {t, " write flag"}, mgmt_we, w);
            if (w) chk(mgmt_wdata == d, {t, " wdata"}, mgmt_wdata, d);
          end
          if (mgmt_we) regs[mgmt_addr] = mgmt_wdata;
          else mgmt_rdata = regs[mgmt_addr];
          mgmt_done = 1'b1;
        end
      end
    end
  end

  // event monitor
  initial begin
    forever begin
      @(negedge clk);
      if (live && (evt_up || evt_down)) begin
        if (ev_kind.size() == 0) begin
          chk(0, "R3 unexpected event", {evt_up, evt_down}, 0);
        end else begin
          int k; int s; string t;
          k = ev_kind.pop_front(); s = ev_spd.pop_front(); t = ev_tag.pop_front();
          chk(evt_up == (k == 1) && evt_down == (k == 0), {t, " event kind"}, evt_up, k);
          chk(evt_speed == s, {t, " event speed"}, evt_speed, s);
        end
      end
    end
  end

  // watchdog
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        chk(0, "watchdog expired", cyc, 100000);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  task automatic pulse_irq();
    @(negedge clk); phy_irq = 1'b1;
    @(negedge clk); phy_irq = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (3) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic settle(input string t);
    chk(ex_addr.size() == 0, {t, " transfers outstanding"}, ex_addr.size(), 0);
    chk(ev_kind.size() == 0, {t, " events outstanding"}, ev_kind.size(), 0);
    chk(link_up == (m_link == 2), {t, " link_up"}, link_up, m_link == 2);
    chk(link_speed == m_spd, {t, " link_speed"}, link_speed, m_spd);
    chk(flow_ctrl == m_fc, {t, " flow_ctrl"}, flow_ctrl, m_fc);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) regs[i] = '0;
    regs[5'h00] = 16'h1140;
    regs[5'h04] = 16'h05E1;
    regs[5'h05] = 16'h0C00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    live = 1;

    // R1 reset state
    chk(link_up == 0 && link_speed == 0, "R1 reset link", {link_up, link_speed}, 0);
    chk(flow_ctrl == 0 && !evt_up && !evt_down, "R1 reset flow/events", {flow_ctrl, evt_up, evt_down}, 0);
    chk(!busy && !mgmt_req, "R1 reset idle", {busy, mgmt_req}, 0);

    // R7 init sequence
    expect_init();
    @(negedge clk); init_start = 1'b1;
    @(negedge clk); init_start = 1'b0;
    wait_idle(); settle("R7");

    // R1/R2 first good status at 1000 Mb/s, partner 11 -> index 11 (R6)
    regs[5'h11] = 16'h0014;
    expect_check(); pulse_irq(); wait_idle(); settle("R1");

    // R4 speed change to 100 Mb/s
    regs[5'h11] = 16'h000C;
    expect_check(); pulse_irq(); wait_idle(); settle("R4");

    // R3 unchanged status: no event
    expect_check(); pulse_irq(); wait_idle(); settle("R3");

    // R3 link down, flow control held (R6)
    regs[5'h11] = 16'h0010;
    regs[5'h05] = 16'h0400;
    expect_check(); pulse_irq(); wait_idle(); settle("R6");
    expect_check(); pulse_irq(); wait_idle(); settle("R3");

    // R2 reserved speed code gives unknown; index 13 symmetric (R6)
    regs[5'h11] = 16'h001C;
    regs[5'h04] = 16'h0C00;
    regs[5'h05] = 16'h0400;
    expect_check(); pulse_irq(); wait_idle(); settle("R2");

    // R4 unknown -> 10 Mb/s; index 14 we-receive (R6)
    regs[5'h11] = 16'h0004;
    regs[5'h05] = 16'h0800;
    expect_check(); pulse_irq(); wait_idle(); settle("R6");

    // R8 interrupts during a busy check collapse into one more check; index 5
    regs[5'h04] = 16'h0400;
    regs[5'h05] = 16'h0400;
    expect_check();
    expect_check();
    pulse_irq();
    @(negedge clk);
    pulse_irq();
    @(negedge clk);
    pulse_irq();
    wait_idle(); settle("R8");

    // R8 init takes precedence over a simultaneous check; speed to 100
    regs[5'h04] = 16'h0801;
    regs[5'h05] = 16'h0C00;
    regs[5'h11] = 16'h000C;
    expect_init();
    expect_check();
    @(negedge clk); init_start = 1'b1; phy_irq = 1'b1;
    @(negedge clk); init_start = 1'b0; phy_irq = 1'b0;
    wait_idle(); settle("R8");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule